// File: doc/BRIEF.md
# LCD Segment Refresh Scan Controller

This block refreshes a multiplexed (dynamic) LCD from a display RAM with no help from software. Once the processor has stored the segment bits, a display counter walks the RAM one bit per instruction-cycle tick. For each common line it reads the full segment row. The row belongs to the common line that will be driven next, so the new segment pattern and the new common line can switch on the same edge.

A scan period lasts either 128 or 256 ticks. In the long setting the row is fetched twice. The local slice of the row is gathered in a shift register and moved in parallel into an output latch when the scan ends. The remaining segments are sent out bit by bit, with a strobe, to an external expansion driver. That driver uses the same latch pulse and the same alternating polarity signal.

The RAM is bit-addressed. Each common line owns a row of SEG_BITS bits, which is 16 bytes with the default parameters. The RAM returns the addressed bit in the same cycle.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: While rst_ni is low, com_o selects line 0 (0001), and seg_o, lclk_o, m_o, ser_stb_o and ser_d_o are all 0.
- R2: ram_addr_o equals next_line*SEG_BITS + idx. Here next_line is the line after the current one, modulo NUM_COM, and idx is the scan position modulo SEG_BITS. The row base is therefore next_line*16 bytes.
- R3: Nothing advances in a cycle where tick_i is low. ram_addr_o holds its value, and no latch pulse and no serial strobe follow.
- R4: A scan lasts 256 ticks when long_scan_i is 1, and 128 ticks when it is 0. The input is sampled on the first tick of each scan. A change in the middle of a scan takes effect only from the next scan.
- R5: One cycle after the final tick of a scan, lclk_o is high for exactly one cycle. On that same edge com_o advances, one-hot, to the next line modulo NUM_COM. com_o stays one-hot at all times.
- R6: seg_o changes only together with the latch pulse. Bit j of seg_o (j < LOCAL_SEGS) then holds the last RAM bit read at scan position j of that scan, which is the bit at line*SEG_BITS + j of the newly selected line.
- R7: A tick at position idx >= LOCAL_SEGS with expand_en_i high produces ser_stb_o = 1 one cycle later, with ser_d_o equal to the bit read. Ticks at positions below LOCAL_SEGS produce no strobe.
- R8: While expand_en_i is 0, ser_stb_o and ser_d_o stay at 0.
- R9: m_o inverts on the latch edge at which com_o wraps to line 0. It holds its value at every other time.
- R10: In the 256-tick setting, the latched local segments come from the second read of the row. A change to the RAM made after the first pass shows up at the end of that same scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Instruction-cycle enable, one RAM bit per high cycle |
| long_scan_i | input | 1 | 1: 256-tick scan, 0: 128-tick scan |
| expand_en_i | input | 1 | Enables the serial stream to the expansion driver |
| ram_bit_i | input | 1 | Display RAM read data for ram_addr_o |
| ram_addr_o | output | $clog2(NUM_COM)+$clog2(SEG_BITS) | Display RAM bit address |
| seg_o | output | LOCAL_SEGS | Latched local segment data |
| com_o | output | NUM_COM | One-hot common line select |
| lclk_o | output | 1 | Latch pulse, one per scan |
| ser_d_o | output | 1 | Serial segment data to the expansion driver |
| ser_stb_o | output | 1 | Qualifies ser_d_o, one per expansion bit |
| m_o | output | 1 | Alternating drive polarity |

## Verification
ram_addr_o is combinational from the registered counters, so the bench checks it shortly after it raises tick_i, before the clock edge. lclk_o, com_o, seg_o, m_o and the serial pair are registered, so each one is due on the edge that consumes the tick. The bench samples them one time unit after that edge.

A model in the bench tracks the scan position, the mode sampled at scan start, the current line, the polarity and the last bit read per local position. From these it predicts each of those values arithmetically. The bench runs sweeps over every line in both scan lengths, inserts idle cycles, switches the mode in the middle of a scan, and rewrites the RAM between the two passes.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  typedef enum logic {
    SCAN_SHORT = 1'b0,
    SCAN_LONG  = 1'b1
  } scan_mode_e;

  function automatic scan_mode_e to_mode(input logic long_sel);
    return long_sel ? SCAN_LONG : SCAN_SHORT;
  endfunction
endpackage

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
  import lcd_scan_pkg::*;
#(
  parameter int unsigned SEG_BITS = 128,
  localparam int unsigned SEG_W   = $clog2(SEG_BITS),
  localparam int unsigned CNT_W   = SEG_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             long_i,
  output logic [SEG_W-1:0] idx_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q, end_cnt;
  scan_mode_e       mode_q, mode_eff;
  logic             first;

  assign first    = (cnt_q == '0);
  // mode is fixed by the first tick of each scan
  assign mode_eff = first ? to_mode(long_i) : mode_q;
  assign end_cnt  = (mode_eff == SCAN_LONG) ? {1'b1, {SEG_W{1'b1}}}
                                            : {1'b0, {SEG_W{1'b1}}};
  assign last_o   = tick_i && (cnt_q == end_cnt);
  assign idx_o    = cnt_q[SEG_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= SCAN_SHORT;
    end else if (tick_i) begin
      if (first) mode_q <= mode_eff;
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_com_seq.sv
module lcd_com_seq #(
  parameter int unsigned NUM_COM = 4,
  localparam int unsigned COM_W  = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               adv_i,
  output logic [COM_W-1:0]   nxt_o,
  output logic [NUM_COM-1:0] com_o,
  output logic               m_o,
  output logic               lclk_o
);
  logic [COM_W-1:0] cur_q;
  logic             m_q, lclk_q;

  assign nxt_o = (cur_q == COM_W'(NUM_COM - 1)) ? '0 : cur_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      m_q    <= 1'b0;
      lclk_q <= 1'b0;
    end else begin
      lclk_q <= adv_i;
      if (adv_i) begin
        cur_q <= nxt_o;
        if (nxt_o == '0) m_q <= ~m_q;  // frame boundary
      end
    end
  end

  for (genvar g = 0; g < NUM_COM; g++) begin : g_com
    assign com_o[g] = (cur_q == COM_W'(g));
  end

  assign m_o    = m_q;
  assign lclk_o = lclk_q;
endmodule

// File: rtl/lcd_seg_path.sv
module lcd_seg_path #(
  parameter int unsigned SEG_BITS   = 128,
  parameter int unsigned LOCAL_SEGS = 32,
  localparam int unsigned SEG_W     = $clog2(SEG_BITS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic                  bit_i,
  input  logic [SEG_W-1:0]      idx_i,
  input  logic                  adv_i,
  input  logic                  expand_i,
  output logic [LOCAL_SEGS-1:0] seg_o,
  output logic                  ser_d_o,
  output logic                  ser_stb_o
);
  logic [LOCAL_SEGS-1:0] sh_q, lat_q;
  logic                  is_ext, ext_go;

  assign is_ext = (idx_i >= SEG_W'(LOCAL_SEGS));
  assign ext_go = tick_i && is_ext && expand_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q      <= '0;
      lat_q     <= '0;
      ser_d_o   <= 1'b0;
      ser_stb_o <= 1'b0;
    end else begin
      // local positions come first in each pass; shift right so idx 0 lands at bit 0
      if (tick_i && !is_ext) sh_q <= {bit_i, sh_q[LOCAL_SEGS-1:1]};
      if (adv_i) lat_q <= sh_q;
      ser_stb_o <= ext_go;
      ser_d_o   <= ext_go && bit_i;
    end
  end

  assign seg_o = lat_q;
endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl #(
  parameter int unsigned NUM_COM    = 4,
  parameter int unsigned SEG_BITS   = 128,
  parameter int unsigned LOCAL_SEGS = 32,
  localparam int unsigned SEG_W     = $clog2(SEG_BITS),
  localparam int unsigned COM_W     = (NUM_COM > 1) ? $clog2(NUM_COM) : 1,
  localparam int unsigned ADDR_W    = COM_W + SEG_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic                  long_scan_i,
  input  logic                  expand_en_i,
  input  logic                  ram_bit_i,
  output logic [ADDR_W-1:0]     ram_addr_o,
  output logic [LOCAL_SEGS-1:0] seg_o,
  output logic [NUM_COM-1:0]    com_o,
  output logic                  lclk_o,
  output logic                  ser_d_o,
  output logic                  ser_stb_o,
  output logic                  m_o
);
  logic [SEG_W-1:0] idx;
  logic [COM_W-1:0] nxt;
  logic             last;

  lcd_scan_timer #(.SEG_BITS(SEG_BITS)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .long_i (long_scan_i),
    .idx_o  (idx),
    .last_o (last)
  );

  lcd_com_seq #(.NUM_COM(NUM_COM)) i_com (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (last),
    .nxt_o  (nxt),
    .com_o  (com_o),
    .m_o    (m_o),
    .lclk_o (lclk_o)
  );

  lcd_seg_path #(.SEG_BITS(SEG_BITS), .LOCAL_SEGS(LOCAL_SEGS)) i_seg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .bit_i     (ram_bit_i),
    .idx_i     (idx),
    .adv_i     (last),
    .expand_i  (expand_en_i),
    .seg_o     (seg_o),
    .ser_d_o   (ser_d_o),
    .ser_stb_o (ser_stb_o)
  );

  // row of the line selected next; SEG_BITS is a power of two
  assign ram_addr_o = {nxt, idx};
endmodule

// File: rtl/lcd_scan_chk.sv
module lcd_scan_chk #(
  parameter int unsigned NUM_COM    = 4,
  parameter int unsigned LOCAL_SEGS = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  tick_i,
  input logic                  expand_en_i,
  input logic [LOCAL_SEGS-1:0] seg_o,
  input logic [NUM_COM-1:0]    com_o,
  input logic                  lclk_o,
  input logic                  ser_d_o,
  input logic                  ser_stb_o,
  input logic                  m_o
);
  AST_COM_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(com_o) == 1);  // R5
  AST_COM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lclk_o |-> $stable(com_o));  // R5
  AST_LCLK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lclk_o |=> !lclk_o);  // R5
  AST_NO_TICK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> (!lclk_o && !ser_stb_o));  // R3
  AST_SER_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !expand_en_i |=> (!ser_stb_o && !ser_d_o));  // R8
  AST_SEG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lclk_o |-> $stable(seg_o));  // R6
  AST_M_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lclk_o || !com_o[0]) |-> $stable(m_o));  // R9
  AST_M_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lclk_o && com_o[0]) |-> (m_o != $past(m_o)));  // R9
endmodule

bind lcd_scan_ctrl lcd_scan_chk #(.NUM_COM(NUM_COM), .LOCAL_SEGS(LOCAL_SEGS)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .expand_en_i (expand_en_i),
  .seg_o       (seg_o),
  .com_o       (com_o),
  .lclk_o      (lclk_o),
  .ser_d_o     (ser_d_o),
  .ser_stb_o   (ser_stb_o),
  .m_o         (m_o)
);

// File: tb/test_lcd_scan_ctrl.sv
module test_lcd_scan_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int SB = 128;
  localparam int LS = 32;
  localparam int AW = $clog2(NC) + $clog2(SB);

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, long_s = 1'b1, expand = 1'b1;
  logic ram_bit;
  logic [AW-1:0] ram_addr;
  logic [LS-1:0] seg;
  logic [NC-1:0] com;
  logic lclk, ser_d, ser_stb, m;

  logic mem [NC*SB];
  assign ram_bit = mem[ram_addr];

  int total = 0, bad = 0;
  int cur = 0, cnt = 0, lm = 0, mexp = 0;
  logic [LS-1:0] capt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_scan_ctrl #(.NUM_COM(NC), .SEG_BITS(SB), .LOCAL_SEGS(LS)) i_lcd_scan_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .long_scan_i(long_s),
    .expand_en_i(expand), .ram_bit_i(ram_bit), .ram_addr_o(ram_addr),
    .seg_o(seg), .com_o(com), .lclk_o(lclk), .ser_d_o(ser_d),
    .ser_stb_o(ser_stb), .m_o(m)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    logic [AW-1:0] a0;
    @(negedge clk);
    tick = 1'b0;
    a0 = ram_addr;
    @(posedge clk); #1;
    chk(ram_addr == a0, "R3 address holds without tick", ram_addr, a0);
    chk(lclk == 1'b0, "R3 no latch pulse without tick", lclk, 0);
    chk(ser_stb == 1'b0, "R3 no strobe without tick", ser_stb, 0);
  endtask

  task automatic step();
    int k, nxt, ea;
    bit last, b;
    @(negedge clk);
    tick = 1'b1;
    if (cnt == 0) lm = long_s;
    k   = cnt % SB;
    nxt = (cur + 1) % NC;
    ea  = nxt * SB + k;
    #1;
    chk(ram_addr == AW'(ea), "R2 ram address", ram_addr, ea);
    b = mem[ea];
    if (k < LS) capt[k] = b;
    last = (cnt == (lm != 0 ? 2*SB - 1 : SB - 1));
    @(posedge clk); #1;
    tick = 1'b0;
    chk(lclk == last, "R4 R5 scan length and latch pulse", lclk, last);
    if (k >= LS) begin
      if (expand) begin
        chk(ser_stb == 1'b1, "R7 serial strobe", ser_stb, 1);
        chk(ser_d == b, "R7 serial data", ser_d, b);
      end else begin
        chk(ser_stb == 1'b0 && ser_d == 1'b0, "R8 serial quiet", {ser_stb, ser_d}, 0);
      end
    end else begin
      chk(ser_stb == 1'b0, "R7 no strobe for local position", ser_stb, 0);
    end
    if (last) begin
      cur = nxt;
      if (cur == 0) mexp ^= 1;
      cnt = 0;
      chk(com == NC'(1 << cur), "R5 common advance", com, 1 << cur);
      chk(seg == capt, "R6 latched local row", seg, capt);
    end else begin
      cnt++;
    end
    chk(m == mexp[0], "R9 polarity", m, mexp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", total);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [LS-1:0] flip_exp;
    int row;
    for (int i = 0; i < NC*SB; i++) mem[i] = (((i*13) + (i/5)) % 7) < 3;

    repeat (3) @(posedge clk);
    #1;
    chk(com == NC'(1), "R1 reset common", com, 1);
    chk(seg == '0, "R1 reset segments", seg, 0);
    chk(lclk == 1'b0 && m == 1'b0, "R1 reset latch and polarity", {lclk, m}, 0);
    chk(ser_stb == 1'b0 && ser_d == 1'b0, "R1 reset serial", {ser_stb, ser_d}, 0);
    chk(ram_addr == AW'(SB), "R2 reset address", ram_addr, SB);
    @(negedge clk);
    rst_n = 1'b1;

    // long scans over every line plus a wrap, expansion on
    long_s = 1'b1; expand = 1'b1;
    repeat ((NC + 1) * 2 * SB) step();

    // short scans, expansion off, idle cycles mixed in
    long_s = 1'b0; expand = 1'b0;
    for (int i = 0; i < NC * SB; i++) begin
      if (i % 17 == 5) idle();
      step();
    end

    // R4: mode change mid-scan applies from the next scan
    long_s = 1'b1; expand = 1'b1;
    repeat (50) step();
    long_s = 1'b0;
    repeat (2*SB - 50 + SB) step();

    // R10: second pass of a long scan supplies the latched row
    long_s = 1'b1;
    repeat (SB) step();
    row = (cur + 1) % NC;
    for (int j = 0; j < LS; j++) begin
      mem[row*SB + j] = ~mem[row*SB + j];
      flip_exp[j] = mem[row*SB + j];
    end
    repeat (SB) step();
    chk(seg == flip_exp, "R10 second pass latched", seg, flip_exp);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule